// File: doc/BRIEF.md
# Protection Key Access Checker

This block decides, one access at a time, whether a memory access may proceed based on the protection key carried in the page's translation entry. It holds a small bank of key slots. Each slot stores a key value and three disable bits that separately block reads, writes and instruction fetches for pages tagged with that key. A check presents the page key and the access kind. One cycle later the block returns either a grant or a fault, and a fault carries a two-bit reason.

Keys whose upper bits are all zero are treated as global keys. A global key never needs a slot. Its low three bits index a separate eight-entry table of disable bits, which software can also program. Key zero is reserved as an unrestricted global key. Slots and table entries are loaded through one write port, and a write is visible to any check issued in the cycle after it.

Top module: `pk_access_check`

## Requirements
- R1: After reset, rsp_valid, rsp_grant and rsp_fault are 0. Every slot is empty, so any non-global key faults with no match. Every global table entry has nothing disabled.
- R2: A check strobed in cycle t produces rsp_valid in cycle t+1, with one response per strobe. rsp_valid is 0 in a cycle that follows no strobe.
- R3: A key whose bits above bit 2 are all zero is global. Its bits [2:0] select a global table entry, and no slot is consulted. cfg_glob=1 writes cfg_dis into table entry cfg_idx[2:0].
- R4: Key 0 is granted for read, write and execute at all times, and writes to global table entry 0 have no effect.
- R5: A non-global key that equals no slot's key faults with reason 2'b01 (no match).
- R6: Disable bits are bit0 read, bit1 write and bit2 execute. Access types are 2'b00 read, 2'b01 write and 2'b10 execute. If the matching slot or global entry has the bit for the requested type set, the check faults with reason 2'b10 (disabled). Otherwise the check is granted with reason 2'b00.
- R7: Access type 2'b11 faults with reason 2'b11 (illegal type), whatever the key.
- R8: When several slots hold the same key, the lowest-numbered matching slot supplies the disable bits.
- R9: A write in cycle t affects checks strobed in cycle t+1 and later. A check strobed in the same cycle as a write sees the old contents.
- R10: When rsp_valid is 1, exactly one of rsp_grant and rsp_fault is 1, and rsp_reason is 2'b00 exactly when the check is granted.
- R11: A slot write (cfg_glob=0) with cfg_idx at or above the slot count (default 8) has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for a slot or a global entry |
| cfg_glob | input | 1 | 1 selects the global table, 0 selects a key slot |
| cfg_idx | input | 4 | Slot index, or global entry in bits [2:0] |
| cfg_key | input | 16 | Key value to store in a slot |
| cfg_dis | input | 3 | Disable bits: bit0 read, bit1 write, bit2 execute |
| chk_valid | input | 1 | Check strobe |
| chk_key | input | 16 | Page key under test |
| chk_type | input | 2 | Access kind: 00 read, 01 write, 10 execute |
| rsp_valid | output | 1 | Result valid, one cycle after the strobe |
| rsp_grant | output | 1 | Access allowed |
| rsp_fault | output | 1 | Access refused |
| rsp_reason | output | 2 | 00 ok, 01 no match, 10 disabled, 11 illegal type |

## Verification
A write to a slot or to the global table can land in the same cycle as a check on the very key being changed. The bench provokes this by driving cfg_we and chk_valid together, first for a new slot key and then for a global entry's disable bits. The scoreboard computes the expected result from the table contents before the write and takes the update into its model only afterwards. A check repeated in the next cycle must then reflect the new contents.

// File: rtl/pk_pkg.sv
package pk_pkg;
  localparam int GIDX_W  = 3;
  localparam int GTBL_N  = 1 << GIDX_W;
  localparam int SLOT_MAX = 16;
  localparam int IDX_W   = $clog2(SLOT_MAX);
  localparam int DIS_W   = 3;

  localparam int DIS_RD = 0;
  localparam int DIS_WR = 1;
  localparam int DIS_EX = 2;

  typedef enum logic [1:0] {
    ACC_RD  = 2'b00,
    ACC_WR  = 2'b01,
    ACC_EX  = 2'b10,
    ACC_BAD = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    RSN_OK       = 2'b00,
    RSN_NOMATCH  = 2'b01,
    RSN_DISABLED = 2'b10,
    RSN_BADTYPE  = 2'b11
  } rsn_e;
endpackage

// File: rtl/pk_key_bank.sv
module pk_key_bank import pk_pkg::*; #(
  parameter int NUM_KEYS = 8,
  parameter int KEY_W    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [KEY_W-1:0] wkey,
  input  logic [DIS_W-1:0] wdis,
  input  logic [KEY_W-1:0] lkey,
  output logic             hit,
  output logic [DIS_W-1:0] hit_dis
);
  logic [KEY_W-1:0] key_q [NUM_KEYS];
  logic [DIS_W-1:0] dis_q [NUM_KEYS];

  for (genvar g = 0; g < NUM_KEYS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        key_q[g] <= '0;
        dis_q[g] <= '0;
      end else if (we && idx == IDX_W'(g)) begin
        key_q[g] <= wkey;
        dis_q[g] <= wdis;
      end
    end

    a_r9_slot_loaded: assert property (@(posedge clk) disable iff (rst)
      (we && idx == IDX_W'(g)) |=> (key_q[g] == $past(wkey) && dis_q[g] == $past(wdis)))
      else $error("slot %0d not loaded", g);
  end

  // Scan downward so the lowest matching slot is the last to assign (R8).
  always_comb begin
    hit     = 1'b0;
    hit_dis = '0;
    for (int i = NUM_KEYS - 1; i >= 0; i--) begin
      if (key_q[i] == lkey) begin
        hit     = 1'b1;
        hit_dis = dis_q[i];
      end
    end
  end
endmodule

// File: rtl/pk_global_table.sv
module pk_global_table import pk_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [GIDX_W-1:0] widx,
  input  logic [DIS_W-1:0]  wdis,
  input  logic [GIDX_W-1:0] lidx,
  output logic [DIS_W-1:0]  ldis
);
  logic [DIS_W-1:0] ent [GTBL_N];

  for (genvar g = 0; g < GTBL_N; g++) begin : g_ent
    if (g == 0) begin : g_fixed
      assign ent[g] = '0;
    end else begin : g_reg
      always_ff @(posedge clk) begin
        if (rst)                             ent[g] <= '0;
        else if (we && widx == GIDX_W'(g))   ent[g] <= wdis;
      end
    end
  end

  assign ldis = ent[lidx];
endmodule

// File: rtl/pk_access_check.sv
module pk_access_check import pk_pkg::*; #(
  parameter int NUM_KEYS = 8,
  parameter int KEY_W    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic             cfg_glob,
  input  logic [3:0]       cfg_idx,
  input  logic [KEY_W-1:0] cfg_key,
  input  logic [2:0]       cfg_dis,
  input  logic             chk_valid,
  input  logic [KEY_W-1:0] chk_key,
  input  logic [1:0]       chk_type,
  output logic             rsp_valid,
  output logic             rsp_grant,
  output logic             rsp_fault,
  output logic [1:0]       rsp_reason
);
  logic             bank_hit;
  logic [DIS_W-1:0] bank_dis;
  logic [DIS_W-1:0] glob_dis;
  logic             is_glob;
  logic [DIS_W-1:0] sel_dis;
  logic             blocked;
  rsn_e             rsn_d;

  pk_key_bank #(.NUM_KEYS(NUM_KEYS), .KEY_W(KEY_W)) u_bank (
    .clk(clk), .rst(rst),
    .we(cfg_we && !cfg_glob), .idx(cfg_idx), .wkey(cfg_key), .wdis(cfg_dis),
    .lkey(chk_key), .hit(bank_hit), .hit_dis(bank_dis)
  );

  pk_global_table u_gtbl (
    .clk(clk), .rst(rst),
    .we(cfg_we && cfg_glob), .widx(cfg_idx[GIDX_W-1:0]), .wdis(cfg_dis),
    .lidx(chk_key[GIDX_W-1:0]), .ldis(glob_dis)
  );

  assign is_glob = (chk_key[KEY_W-1:GIDX_W] == '0);
  assign sel_dis = is_glob ? glob_dis : bank_dis;

  always_comb begin
    case (acc_e'(chk_type))
      ACC_RD:  blocked = sel_dis[DIS_RD];
      ACC_WR:  blocked = sel_dis[DIS_WR];
      ACC_EX:  blocked = sel_dis[DIS_EX];
      default: blocked = 1'b1;
    endcase
    if (acc_e'(chk_type) == ACC_BAD)  rsn_d = RSN_BADTYPE;
    else if (!is_glob && !bank_hit)   rsn_d = RSN_NOMATCH;
    else if (blocked)                 rsn_d = RSN_DISABLED;
    else                              rsn_d = RSN_OK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_grant  <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_reason <= 2'b00;
    end else begin
      rsp_valid  <= chk_valid;
      rsp_grant  <= chk_valid && (rsn_d == RSN_OK);
      rsp_fault  <= chk_valid && (rsn_d != RSN_OK);
      rsp_reason <= chk_valid ? rsn_d : RSN_OK;
    end
  end

  a_r2_rsp_follows: assert property (@(posedge clk) disable iff (rst)
    chk_valid |=> rsp_valid) else $error("R2 response missing");
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !chk_valid |=> !rsp_valid) else $error("R2 spurious response");
  a_r10_one_outcome: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_grant != rsp_fault)) else $error("R10 outcome");
  a_r10_reason_ok: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_grant == (rsp_reason == 2'b00))) else $error("R10 reason");
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (!rsp_grant && !rsp_fault)) else $error("R10 idle");
  a_r4_zero_key: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && chk_key == '0 && chk_type != 2'b11) |=> rsp_grant)
    else $error("R4 key zero refused");
  a_r7_bad_type: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && chk_type == 2'b11) |=> (rsp_fault && rsp_reason == 2'b11))
    else $error("R7 illegal type");
endmodule

// File: tb/tb_pk_access_check.sv
`timescale 1ns/1ps
module tb_pk_access_check;
  localparam int NK = 8;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we, cfg_glob;
  logic [3:0]  cfg_idx;
  logic [15:0] cfg_key;
  logic [2:0]  cfg_dis;
  logic        chk_valid;
  logic [15:0] chk_key;
  logic [1:0]  chk_type;
  logic        rsp_valid, rsp_grant, rsp_fault;
  logic [1:0]  rsp_reason;

  int checks = 0;
  int errors = 0;

  logic [15:0] mk [16];
  logic [2:0]  md [16];
  logic [2:0]  mg [8];
  logic [1:0]  exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  pk_access_check #(.NUM_KEYS(NK), .KEY_W(16)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_glob(cfg_glob), .cfg_idx(cfg_idx),
    .cfg_key(cfg_key), .cfg_dis(cfg_dis), .chk_valid(chk_valid), .chk_key(chk_key),
    .chk_type(chk_type), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
    .rsp_fault(rsp_fault), .rsp_reason(rsp_reason)
  );

  function automatic logic [1:0] model(input logic [15:0] k, input logic [1:0] t);
    logic [2:0] d;
    logic       found;
    if (t == 2'b11) return 2'b11;
    found = 1'b0;
    d = 3'b000;
    if (k[15:3] == 13'd0) begin
      found = 1'b1;
      d = mg[k[2:0]];
    end else begin
      for (int i = NK - 1; i >= 0; i--)
        if (mk[i] == k) begin found = 1'b1; d = md[i]; end
    end
    if (!found) return 2'b01;
    if (d[t]) return 2'b10;
    return 2'b00;
  endfunction

  task automatic model_write(input logic g, input logic [3:0] i,
                             input logic [15:0] k, input logic [2:0] d);
    if (g) begin
      if (i[2:0] != 3'd0) mg[i[2:0]] = d;
    end else if (int'(i) < NK) begin
      mk[i] = k;
      md[i] = d;
    end
  endtask

  task automatic note(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic wr(input logic g, input logic [3:0] i,
                    input logic [15:0] k, input logic [2:0] d);
    cfg_we = 1'b1; cfg_glob = g; cfg_idx = i; cfg_key = k; cfg_dis = d;
    @(negedge clk);
    cfg_we = 1'b0;
    model_write(g, i, k, d);
  endtask

  task automatic chk(input logic [15:0] k, input logic [1:0] t, input string tag);
    chk_valid = 1'b1; chk_key = k; chk_type = t;
    exp_q.push_back(model(k, t));
    tag_q.push_back(tag);
    @(negedge clk);
    chk_valid = 1'b0;
  endtask

  // Write and check in one cycle: expectation from the old contents (R9).
  task automatic wr_chk(input logic g, input logic [3:0] i, input logic [15:0] k,
                        input logic [2:0] d, input logic [15:0] ck,
                        input logic [1:0] t, input string tag);
    cfg_we = 1'b1; cfg_glob = g; cfg_idx = i; cfg_key = k; cfg_dis = d;
    chk_valid = 1'b1; chk_key = ck; chk_type = t;
    exp_q.push_back(model(ck, t));
    tag_q.push_back(tag);
    @(negedge clk);
    cfg_we = 1'b0; chk_valid = 1'b0;
    model_write(g, i, k, d);
  endtask

  // Monitor: compares each response with the scoreboard head.
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) begin
        note(1'b0, "R2", "response with no pending check (act valid=1 exp 0)");
      end else begin
        logic [1:0] e;
        string      tg;
        e  = exp_q.pop_front();
        tg = tag_q.pop_front();
        note(rsp_reason == e, tg,
             $sformatf("reason act %0d exp %0d", rsp_reason, e));
        note((rsp_grant ^ rsp_fault) && (rsp_grant == (e == 2'b00)), "R10",
             $sformatf("grant/fault act %0b/%0b exp grant %0b",
                       rsp_grant, rsp_fault, e == 2'b00));
      end
    end
  end

  task automatic run_tests();
    for (int i = 0; i < 16; i++) begin mk[i] = '0; md[i] = '0; end
    for (int i = 0; i < 8; i++) mg[i] = '0;
    rst = 1'b1; cfg_we = 0; cfg_glob = 0; cfg_idx = 0; cfg_key = 0; cfg_dis = 0;
    chk_valid = 0; chk_key = 0; chk_type = 0;
    repeat (3) @(negedge clk);
    note(!rsp_valid && !rsp_grant && !rsp_fault, "R1",
         $sformatf("outputs in reset act %0b%0b%0b exp 000", rsp_valid, rsp_grant, rsp_fault));
    rst = 1'b0;
    @(negedge clk);
    note(!rsp_valid, "R1", $sformatf("idle valid act %0b exp 0", rsp_valid));
    chk(16'h0008, 2'b00, "R1");
    chk(16'h0006, 2'b01, "R1");
    chk(16'h0003, 2'b10, "R1");

    // R3 global entries
    wr(1'b1, 4'd5, 16'h0, 3'b010);
    chk(16'h0005, 2'b01, "R3");
    chk(16'h0005, 2'b00, "R3");
    chk(16'h0003, 2'b10, "R3");
    wr(1'b1, 4'd3, 16'h0, 3'b100);
    chk(16'h0003, 2'b10, "R3");

    // R4 key zero stays unrestricted
    wr(1'b1, 4'd0, 16'h0, 3'b111);
    chk(16'h0000, 2'b00, "R4");
    chk(16'h0000, 2'b01, "R4");
    chk(16'h0000, 2'b10, "R4");

    // R5 no match
    chk(16'h1234, 2'b00, "R5");
    chk(16'hFFF8, 2'b01, "R5");

    // R6 slot disables
    wr(1'b0, 4'd2, 16'h1234, 3'b100);
    chk(16'h1234, 2'b00, "R6");
    chk(16'h1234, 2'b01, "R6");
    chk(16'h1234, 2'b10, "R6");
    wr(1'b0, 4'd3, 16'hBEEF, 3'b011);
    chk(16'hBEEF, 2'b00, "R6");
    chk(16'hBEEF, 2'b01, "R6");
    chk(16'hBEEF, 2'b10, "R6");

    // R7 illegal type
    chk(16'h0000, 2'b11, "R7");
    chk(16'h1234, 2'b11, "R7");

    // R8 lowest slot wins
    wr(1'b0, 4'd5, 16'h1234, 3'b001);
    chk(16'h1234, 2'b00, "R8");
    wr(1'b0, 4'd1, 16'h1234, 3'b010);
    chk(16'h1234, 2'b01, "R8");
    chk(16'h1234, 2'b00, "R8");
    chk(16'h1234, 2'b10, "R8");

    // R9 write and check collide
    wr_chk(1'b0, 4'd0, 16'h7777, 3'b000, 16'h7777, 2'b00, "R9");
    chk(16'h7777, 2'b00, "R9");
    wr_chk(1'b1, 4'd6, 16'h0, 3'b001, 16'h0006, 2'b00, "R9");
    chk(16'h0006, 2'b00, "R9");
    wr_chk(1'b0, 4'd1, 16'h2222, 3'b000, 16'h1234, 2'b01, "R9");
    chk(16'h1234, 2'b01, "R9");

    // R11 out-of-range slot index
    wr(1'b0, 4'd9, 16'h4444, 3'b000);
    chk(16'h4444, 2'b00, "R11");
    wr(1'b0, 4'd15, 16'h5555, 3'b000);
    chk(16'h5555, 2'b01, "R11");

    // R2 back-to-back stream, then silence
    for (int n = 0; n < 6; n++) begin
      chk_valid = 1'b1; chk_key = (n % 2 == 0) ? 16'hBEEF : 16'h0005; chk_type = 2'(n % 3);
      exp_q.push_back(model(chk_key, chk_type));
      tag_q.push_back("R2");
      @(negedge clk);
    end
    chk_valid = 1'b0;
    @(negedge clk);
    repeat (3) begin
      @(negedge clk);
      note(!rsp_valid, "R2", $sformatf("idle valid act %0b exp 0", rsp_valid));
    end
    note(exp_q.size() == 0, "R2", $sformatf("pending act %0d exp 0", exp_q.size()));
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: act expired exp finished");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule